// File: doc/BRIEF.md
# Pipelined Switch Allocator with Request Masking

This block grants crossbar passage for an input-buffered on-chip router with N input ports and N output ports. Every input shows the flit at the front of its buffer: a valid bit, the output it is headed for, and whether it opens, continues or closes a packet. Each output keeps a credit count of free slots in the downstream buffer, an open/closed flag, and the index of the input that currently owns it. A round-robin arbiter per output picks one requester. Its choice is registered, so the grant appears, and the winning flit leaves its buffer, one cycle after the request.

At the moment a request wins, the output state is updated: one credit is spent, an opening flit closes the output to every other input and records the owner, and a closing flit opens it again. Because the grant is still in flight for one cycle, an input that is being granted withholds its request in that same cycle. Without that mask, the flit now leaving would win a second time. The cost is one empty cycle after every flit, so a packet of L flits occupies its output for about 2L cycles. Credit-return pulses from downstream refill the counters, which stop at the buffer depth.

Top module: `sa_pipe_alloc`

## Requirements
- R1: A request raised in cycle t shows up as grant bit `out_gnt[o*N+i]` (output o, input i) in cycle t+1. `in_deq[i]` is high in the same cycle t+1, and the front flit of input i leaves at the end of that cycle.
- R2: Each output's credit count starts at DEPTH after reset. It drops by one for every request the output grants and rises by one for every cycle `credit_ret[o]` is high, never going above DEPTH. No request for an output is raised while its count is zero.
- R3: In any cycle, each output grants at most one input and each input is granted by at most one output.
- R4: Once an opening flit (kind 0) wins an output, no other input's opening flit is granted that output from the next cycle onward until the owner's closing flit is granted. Flits of different packets are never interleaved at an output.
- R5: A granted closing flit (kind 2) reopens its output, so a waiting opening flit can request in the following cycle.
- R6: An input whose grant is visible in a cycle raises no request in that cycle. No input is dequeued in two consecutive cycles, and successive flits of a packet leave two cycles apart.
- R7: While an output is owned, a continuing flit (kind 1, or the unused code 3) or a closing flit from the owning input is always granted when it requests.
- R8: Each output arbitrates round-robin. After reset, input 0 has the highest priority. When an opening flit wins, priority moves to the input just after the winner, wrapping from N-1 to 0.
- R9: Out of reset, no grant and no dequeue is asserted and every output is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | N | Front flit of input i is present |
| in_dest | input | N*IW | Target output of input i, field `[i*IW +: IW]` |
| in_kind | input | 2*N | Flit kind of input i, field `[2*i +: 2]`: 0 opening, 1 continuing, 2 closing, 3 continuing |
| credit_ret | input | N | One-cycle pulse: one slot freed downstream of output o |
| out_gnt | output | N*N | Registered grants; bit `o*N+i` routes input i to output o |
| in_deq | output | N | Input i's front flit leaves this cycle |

## Verification
The bench replays packet mixes on a four-port configuration and predicts each flit's departure cycle arithmetically. It targets three-way contention for one output, where a mask missing from R6 would send back-to-back dequeues or a phantom flit, and a lock missing from R4 would let a second opening flit break into a packet. Rotation is checked in two rounds at one output: a pointer that ignores the winner gives the wrong departure order. The bench drains the credits to zero to catch a counter that wraps or goes on granting. It then floods the return line to catch a counter that climbs past DEPTH and lets six flits through instead of four.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
// Shared types of the switch allocator.
package sa_pkg;
    typedef enum logic [1:0] {
        FK_OPEN  = 2'd0,
        FK_MID   = 2'd1,
        FK_CLOSE = 2'd2,
        FK_SPARE = 2'd3
    } flit_kind_e;
endpackage

// File: rtl/sa_req_gen.sv
`timescale 1ns/1ps
// Request generator for one input port.
// Turns the front flit into a one-hot request toward its target output.
// Assumes: out_open/out_owner/credit_ok are the registered state of the outputs;
// granted is the registered grant of this input (request mask).
module sa_req_gen
    import sa_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2,
    parameter int ME = 0
) (
    input  logic            valid,
    input  logic [IW-1:0]   dest,
    input  logic [1:0]      kind,
    input  logic            granted,
    input  logic [N-1:0]    out_open,
    input  logic [N-1:0]    credit_ok,
    input  logic [N*IW-1:0] out_owner,
    output logic [N-1:0]    req
);
    logic dest_ok;
    logic is_open;

    assign dest_ok = ({1'b0, dest} < (IW+1)'(N));
    assign is_open = (flit_kind_e'(kind) == FK_OPEN);

    // Qualify the front flit by mask, credit and output ownership.
    always_comb begin
        req = '0;
        if (valid && !granted && dest_ok && credit_ok[dest]) begin
            if (is_open)
                req[dest] = out_open[dest];
            else
                req[dest] = !out_open[dest] && (out_owner[dest*IW +: IW] == IW'(ME));
        end
    end
endmodule

// File: rtl/sa_rr_arb.sv
`timescale 1ns/1ps
// Round-robin arbiter for one output.
// Picks the first requester at or after the priority pointer.
// Assumes: adv is high only when the current winner is an opening flit.
module sa_rr_arb #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic [N-1:0]  win,
    output logic [IW-1:0] win_idx,
    output logic          any
);
    logic [IW-1:0] ptr_q;

    // Scan the requesters starting at the pointer.
    always_comb begin
        win     = '0;
        win_idx = '0;
        any     = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(ptr_q) + k;
            if (c >= N) c = c - N;
            if (!any && req[c]) begin
                any     = 1'b1;
                win[c]  = 1'b1;
                win_idx = IW'(c);
            end
        end
    end

    // Move priority past the winner of an opening flit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (adv && any)
            ptr_q <= (int'(win_idx) == N-1) ? '0 : win_idx + 1'b1;
    end

    AST_ARB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win)); // R3
    AST_ARB_WIN_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n) any |-> (win & ~req) == '0); // R1
    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !adv |=> $stable(ptr_q)); // R8
endmodule

// File: rtl/sa_out_state.sv
`timescale 1ns/1ps
// State of one output: credit count, open flag and owning input.
// Updated in the cycle a request wins (state update step).
// Assumes: won is at most one win per cycle; cr_pulse is one credit per cycle.
module sa_out_state
    import sa_pkg::*;
#(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          won,
    input  logic [1:0]    won_kind,
    input  logic [IW-1:0] won_idx,
    input  logic          cr_pulse,
    output logic          open_q,
    output logic [IW-1:0] owner_q,
    output logic          credit_ok
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [CW-1:0] credit_q;

    assign credit_ok = (credit_q != '0);

    // Spend a credit on a win, refill on a return pulse, cap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)
            credit_q <= FULL;
        else if (won && !cr_pulse)
            credit_q <= credit_q - 1'b1;
        else if (cr_pulse && !won && credit_q != FULL)
            credit_q <= credit_q + 1'b1;
    end

    // Close on an opening winner, reopen on a closing winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q  <= 1'b1;
            owner_q <= '0;
        end else if (won) begin
            if (flit_kind_e'(won_kind) == FK_OPEN) begin
                open_q  <= 1'b0;
                owner_q <= won_idx;
            end else if (flit_kind_e'(won_kind) == FK_CLOSE) begin
                open_q  <= 1'b1;
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) won |-> credit_q != '0); // R2
    AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n) credit_q <= FULL); // R2
    AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (won && flit_kind_e'(won_kind) == FK_CLOSE) |=> open_q); // R5
    AST_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && !won) |=> $stable(owner_q)); // R4
    logic unused_n;
    assign unused_n = (N > 0);
endmodule

// File: rtl/sa_pipe_alloc.sv
`timescale 1ns/1ps
// Pipelined switch allocator, N inputs by N outputs.
// Requests are arbitrated per output and the winners registered, so grants
// and dequeues appear one cycle later. A granted input masks its own request
// in the grant cycle; owned outputs admit only their owner's later flits.
// Assumes: every packet starts with an opening flit and ends with a closing one.
module sa_pipe_alloc
    import sa_pkg::*;
#(
    parameter int N     = 4,
    parameter int DEPTH = 4,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    in_valid,
    input  logic [N*IW-1:0] in_dest,
    input  logic [2*N-1:0]  in_kind,
    input  logic [N-1:0]    credit_ret,
    output logic [N*N-1:0]  out_gnt,
    output logic [N-1:0]    in_deq
);
    logic [N-1:0]    req_row [N];
    logic [N-1:0]    req_col [N];
    logic [N-1:0]    win     [N];
    logic [N-1:0]    gnt_q   [N];
    logic [IW-1:0]   win_idx [N];
    logic [N-1:0]    win_any;
    logic [N-1:0]    out_open;
    logic [N-1:0]    credit_ok;
    logic [N*IW-1:0] out_owner;

    // Dequeue an input whose column carries a registered grant.
    always_comb begin
        in_deq = '0;
        for (int o = 0; o < N; o++)
            in_deq = in_deq | gnt_q[o];
    end

    for (genvar i = 0; i < N; i++) begin : g_in
        sa_req_gen #(.N(N), .IW(IW), .ME(i)) u_req (
            .valid     (in_valid[i]),
            .dest      (in_dest[i*IW +: IW]),
            .kind      (in_kind[2*i +: 2]),
            .granted   (in_deq[i]),
            .out_open  (out_open),
            .credit_ok (credit_ok),
            .out_owner (out_owner),
            .req       (req_row[i])
        );
        for (genvar o = 0; o < N; o++) begin : g_tr
            assign req_col[o][i] = req_row[i][o];
        end

        AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
            in_deq[i] |=> !in_deq[i]); // R6
    end

    for (genvar o = 0; o < N; o++) begin : g_out
        logic [1:0] kind_w;
        logic       adv;

        assign kind_w = in_kind[2*win_idx[o] +: 2];
        assign adv    = win_any[o] && (flit_kind_e'(kind_w) == FK_OPEN);

        sa_rr_arb #(.N(N), .IW(IW)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req_col[o]),
            .adv     (adv),
            .win     (win[o]),
            .win_idx (win_idx[o]),
            .any     (win_any[o])
        );

        sa_out_state #(.N(N), .IW(IW), .DEPTH(DEPTH)) u_st (
            .clk       (clk),
            .rst_n     (rst_n),
            .won       (win_any[o]),
            .won_kind  (kind_w),
            .won_idx   (win_idx[o]),
            .cr_pulse  (credit_ret[o]),
            .open_q    (out_open[o]),
            .owner_q   (out_owner[o*IW +: IW]),
            .credit_ok (credit_ok[o])
        );

        // Register the arbitration result as next cycle's grant.
        always_ff @(posedge clk) begin
            if (!rst_n) gnt_q[o] <= '0;
            else        gnt_q[o] <= win[o];
        end

        assign out_gnt[o*N +: N] = gnt_q[o];

        AST_ONE_GNT_PER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(gnt_q[o])); // R3
        AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt_q[o] & ~$past(req_col[o])) == '0); // R1
        AST_OWNER_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_open[o] && req_col[o][out_owner[o*IW +: IW]]) |-> win[o][out_owner[o*IW +: IW]]); // R7
        AST_CLOSED_NO_OPENER: assert property (@(posedge clk) disable iff (!rst_n)
            (!out_open[o] && win_any[o]) |-> win_idx[o] == out_owner[o*IW +: IW]); // R4
    end

    AST_ONE_OUT_PER_IN: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_gnt) == $countones(in_deq)); // R3
endmodule

// File: tb/test_sa_pipe_alloc.sv
`timescale 1ns/1ps
module test_sa_pipe_alloc;
    localparam int N = 4, DEPTH = 4, IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]    in_valid, credit_ret, in_deq;
    logic [N*IW-1:0] in_dest;
    logic [2*N-1:0]  in_kind;
    logic [N*N-1:0]  out_gnt;

    always #2 clk = ~clk;

    sa_pipe_alloc #(.N(N), .DEPTH(DEPTH)) i_sa_pipe_alloc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_kind(in_kind), .credit_ret(credit_ret), .out_gnt(out_gnt), .in_deq(in_deq)
    );

    int checks = 0, errors = 0, cyc_n = 0;
    int qd [N][8];
    logic [1:0] qk [N][8];
    int rd [N], wr [N];
    int dlog [N][8];
    logic [N-1:0] pop_pend, prev_deq, cr_req, gnt_seen;
    bit auto_ret;
    bit own_busy [N];
    int own_in [N];

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < N; i++) begin
            if (pop_pend[i]) rd[i]++;
            in_valid[i] = (rd[i] < wr[i]);
            in_dest[i*IW +: IW] = in_valid[i] ? IW'(qd[i][rd[i]]) : '0;
            in_kind[2*i +: 2]   = in_valid[i] ? qk[i][rd[i]] : 2'd0;
        end
        credit_ret = cr_req | (auto_ret ? gnt_seen : '0);
        cr_req   = '0;
        pop_pend = '0;
    endtask

    task automatic monitor();
        for (int o = 0; o < N; o++) begin
            chk($countones(out_gnt[o*N +: N]) <= 1, "R3 grants at one output",
                $countones(out_gnt[o*N +: N]), 1);
            gnt_seen[o] = |out_gnt[o*N +: N];
        end
        for (int i = 0; i < N; i++) begin
            if (in_deq[i]) begin
                if (rd[i] >= wr[i]) begin
                    chk(1'b0, "R6 dequeue of an absent flit", rd[i], wr[i]);
                end else begin
                    int d;
                    logic [1:0] k;
                    d = qd[i][rd[i]];
                    k = qk[i][rd[i]];
                    chk(out_gnt[d*N + i], "R1 grant bit at target output", 0, 1);
                    chk(!prev_deq[i], "R6 consecutive dequeues", 1, 0);
                    if (k == 2'd0) begin
                        chk(!own_busy[d], "R4 opening flit into held output", own_in[d], -1);
                        own_busy[d] = 1'b1;
                        own_in[d]   = i;
                    end else begin
                        chk(own_busy[d] && own_in[d] == i, "R4 interleaved flit", own_in[d], i);
                        if (k == 2'd2) own_busy[d] = 1'b0;
                    end
                    dlog[i][rd[i]] = cyc_n;
                    pop_pend[i] = 1'b1;
                end
            end
        end
        prev_deq = in_deq;
    endtask

    task automatic cyc();
        @(posedge clk);
        cyc_n++;
        #1 drive();
        @(negedge clk);
        monitor();
    endtask

    task automatic run(int k);
        repeat (k) cyc();
    endtask

    task automatic push(int i, int d, int k);
        qd[i][wr[i]] = d;
        qk[i][wr[i]] = 2'(k);
        wr[i]++;
    endtask

    task automatic pkt(int i, int d, int len);
        push(i, d, 0);
        for (int j = 0; j < len - 2; j++) push(i, d, 1);
        push(i, d, 2);
    endtask

    task automatic clear();
        for (int i = 0; i < N; i++) begin
            rd[i] = 0;
            wr[i] = 0;
            for (int j = 0; j < 8; j++) dlog[i][j] = -1;
        end
        pop_pend = '0;
    endtask

    task automatic exp_deq(int i, int k, int exp, string tag);
        chk(dlog[i][k] == exp, tag, dlog[i][k], exp);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual cycles 5000 expected fewer");
        summary();
        $finish;
    end

    initial begin
        int t0, r, cnt;
        in_valid = '0; in_dest = '0; in_kind = '0; credit_ret = '0;
        prev_deq = '0; cr_req = '0; gnt_seen = '0; auto_ret = 1'b1;
        for (int o = 0; o < N; o++) begin own_busy[o] = 1'b0; own_in[o] = -1; end
        clear();
        run(3);
        rst_n = 1'b1;
        run(2);
        chk(out_gnt == '0, "R9 no grant after reset", int'(out_gnt), 0);
        chk(in_deq == '0, "R9 no dequeue after reset", int'(in_deq), 0);

        // Single three-flit packet: R1 latency, R6 spacing
        clear(); pkt(0, 1, 3); t0 = cyc_n + 1; run(8);
        exp_deq(0, 0, t0 + 1, "R1 opening flit dequeue cycle");
        exp_deq(0, 1, t0 + 3, "R6 second flit dequeue cycle");
        exp_deq(0, 2, t0 + 5, "R6 closing flit dequeue cycle");

        // Three inputs contend for output 2: R4 lock, R5 reopen, R8 rotation
        clear(); pkt(0, 2, 2); pkt(1, 2, 2); pkt(2, 2, 2); t0 = cyc_n + 1; run(12);
        exp_deq(0, 0, t0 + 1, "R8 input 0 first after reset");
        exp_deq(0, 1, t0 + 3, "R7 owner closing flit");
        exp_deq(1, 0, t0 + 4, "R5 reopened output to input 1");
        exp_deq(1, 1, t0 + 6, "R7 owner closing flit input 1");
        exp_deq(2, 0, t0 + 7, "R4 input 2 held off until reopen");
        exp_deq(2, 1, t0 + 9, "R5 closing flit input 2");

        // Second round at output 2: priority starts after input 2
        clear(); pkt(0, 2, 2); pkt(1, 2, 2); pkt(3, 2, 2); t0 = cyc_n + 1; run(12);
        exp_deq(3, 0, t0 + 1, "R8 input 3 wins after input 2");
        exp_deq(0, 0, t0 + 4, "R8 input 0 next");
        exp_deq(1, 0, t0 + 7, "R8 input 1 last");
        exp_deq(1, 1, t0 + 9, "R5 final closing flit");

        // Credit exhaustion and return on output 3
        auto_ret = 1'b0;
        clear(); pkt(0, 3, 6); t0 = cyc_n + 1; run(14);
        exp_deq(0, 3, t0 + 7, "R2 fourth flit uses last credit");
        exp_deq(0, 4, -1, "R2 stall at zero credit");
        cr_req[3] = 1'b1; r = cyc_n + 1; run(6);
        exp_deq(0, 4, r + 2, "R2 one returned credit releases one flit");
        exp_deq(0, 5, -1, "R2 stall again at zero credit");
        cr_req[3] = 1'b1; r = cyc_n + 1; run(6);
        exp_deq(0, 5, r + 2, "R2 second return releases closing flit");

        // Saturation: ten returns leave exactly DEPTH credits
        for (int j = 0; j < 10; j++) begin cr_req[3] = 1'b1; run(1); end
        clear(); pkt(1, 3, 6); run(16);
        cnt = 0;
        for (int j = 0; j < 6; j++) if (dlog[1][j] != -1) cnt++;
        chk(cnt == DEPTH, "R2 credit count capped at DEPTH", cnt, DEPTH);
        cr_req[3] = 1'b1; run(5);
        cr_req[3] = 1'b1; run(6);
        chk(rd[1] == wr[1], "R2 packet drains after returns", rd[1], wr[1]);

        // Owned output admits owner flits despite a waiting opener; other output in parallel
        auto_ret = 1'b1;
        clear(); pkt(0, 0, 4); pkt(1, 0, 2); pkt(3, 1, 2); t0 = cyc_n + 1; run(14);
        exp_deq(0, 1, t0 + 3, "R7 continuing flit granted");
        exp_deq(0, 2, t0 + 5, "R7 second continuing flit granted");
        exp_deq(0, 3, t0 + 7, "R7 closing flit granted");
        exp_deq(1, 0, t0 + 8, "R5 waiting opener after reopen");
        exp_deq(3, 0, t0 + 1, "R3 other output grants in same cycle");
        exp_deq(3, 1, t0 + 3, "R6 parallel packet spacing");

        summary();
        $finish;
    end
endmodule